// File: doc/BRIEF.md
# I2C Save/Restore Command Target

This block is the serial front end of a configuration store. It listens on an I2C bus for a two-byte write. The first byte is the device address, and the second is a command byte that asks the backend to save its configuration or to restore it. The command is not acted on when its byte ends. It is held and launched as a single-cycle pulse only once the controller issues STOP.

While the backend reports that it is still working, the block refuses every transfer by leaving the acknowledge bit released. Other controllers on the bus therefore see it as busy. The bus pins are oversampled by the system clock through two-flop synchronisers. SDA is driven only through an open-drain pull-down enable.

Top module: `cmd_i2c_target`

## Requirements
- R1: A byte made of the 7-bit address `DEV_ADDR` (sent MSB first) and an R/W bit of 0 is acknowledged: `sda_oe` pulls SDA low during the ninth SCL high phase. A byte with a different address, or with R/W at 1, is not acknowledged. In that case the rest of the transfer is neither acknowledged nor acted on. `sda_oe` changes only while SCL is low, except when a START or STOP condition forces it off.
- R2: In an accepted command byte, bits [1:0] = 2'b01 select save and 2'b10 select restore. Bits [7:2] have no effect. `save_go` and `restore_go` are never high together.
- R3: A decoded command produces exactly one single-cycle pulse on its output, and only after the STOP condition. No pulse appears between the end of the command byte and STOP.
- R4: While `busy` is high at the end of a byte, that byte is not acknowledged and no command is launched.
- R5: Once `busy` is low again, address and command bytes are acknowledged normally.
- R6: A repeated START before STOP discards any held command.
- R7: A command byte with bits [1:0] equal to 2'b00 or 2'b11 is acknowledged but launches nothing.
- R8: After reset, `sda_oe`, `save_go` and `restore_go` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line |
| sda_in | input | 1 | Raw SDA line |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| busy | input | 1 | Backend is executing a save or restore |
| save_go | output | 1 | One-cycle save launch pulse |
| restore_go | output | 1 | One-cycle restore launch pulse |

## Verification
A wrong bit counter or shift register shows up at the ninth SCL high phase of the first byte. The acknowledge then appears where it should be absent, or is missing where it is due, so the error is visible within one byte time. A wrong held-command state only becomes visible after STOP. It shows as a missing pulse, a pulse of the wrong kind, or a pulse surviving a repeated START, a few system clocks after SDA rises. Running a busy transfer directly before an idle one exposes state that fails to recover.

// File: rtl/cmd_i2c_pkg.sv
package cmd_i2c_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_CMD,
      ST_CMD_ACK,
      ST_HOLD,
      ST_SKIP
   } tgt_state_e;

   typedef enum logic [1:0] {
      OP_NONE,
      OP_SAVE,
      OP_RESTORE
   } op_e;

   function automatic op_e decode_op(input logic [1:0] lo);
      case (lo)
         2'b01:   decode_op = OP_SAVE;
         2'b10:   decode_op = OP_RESTORE;
         default: decode_op = OP_NONE;
      endcase
   endfunction

endpackage

// File: rtl/cmd_i2c_sync.sv
module cmd_i2c_sync #(
   parameter int WIDTH   = 2,
   parameter int STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cmd_i2c_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("cmd_i2c_sync: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain[s] <= {WIDTH{RST_VAL}};
            end else begin
               chain[s] <= (s == 0) ? d_in : chain[(s == 0) ? 0 : s-1];
            end
         end
      end
   endgenerate

   assign d_out = chain[STAGES-1];

endmodule

// File: rtl/cmd_i2c_cond.sv
module cmd_i2c_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic start_det,
   output logic stop_det,
   output logic scl_rise,
   output logic scl_fall
);

   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   always_comb begin
      start_det = scl_s & scl_p & sda_p & ~sda_s;
      stop_det  = scl_s & scl_p & ~sda_p & sda_s;
      scl_rise  = scl_s & ~scl_p;
      scl_fall  = ~scl_s & scl_p;
   end

endmodule

// File: rtl/cmd_i2c_fsm.sv
module cmd_i2c_fsm
   import cmd_i2c_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h6A
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   input  logic start_i,
   input  logic stop_i,
   input  logic rise_i,
   input  logic fall_i,
   input  logic busy_i,
   output logic oe_o,
   output logic save_o,
   output logic restore_o
);

   localparam int BYTE_BITS = ADDR_W + 1;
   localparam int CNT_W     = $clog2(BYTE_BITS);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS - 1);

   generate
      if (BYTE_BITS != 8) begin : g_bad_addr
         $error("cmd_i2c_fsm: ADDR_W must be 7");
      end
   endgenerate

   tgt_state_e           state;
   logic [BYTE_BITS-1:0] shreg;
   logic [CNT_W-1:0]     bitcnt;
   logic                 byte_full;
   logic                 oe_q;
   op_e                  pend;
   logic                 save_q, restore_q;

   logic addr_ok;
   assign addr_ok = (shreg[BYTE_BITS-1:1] == DEV_ADDR) && !shreg[0] && !busy_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         shreg     <= '0;
         bitcnt    <= '0;
         byte_full <= 1'b0;
         oe_q      <= 1'b0;
         pend      <= OP_NONE;
         save_q    <= 1'b0;
         restore_q <= 1'b0;
      end else begin
         save_q    <= 1'b0;
         restore_q <= 1'b0;
         if (start_i) begin
            state     <= ST_ADDR;
            bitcnt    <= '0;
            byte_full <= 1'b0;
            oe_q      <= 1'b0;
            pend      <= OP_NONE;
         end else if (stop_i) begin
            state     <= ST_IDLE;
            oe_q      <= 1'b0;
            byte_full <= 1'b0;
            if (state == ST_HOLD) begin
               save_q    <= (pend == OP_SAVE);
               restore_q <= (pend == OP_RESTORE);
            end
            pend <= OP_NONE;
         end else begin
            case (state)
               ST_ADDR, ST_CMD: begin
                  if (rise_i && !byte_full) begin
                     shreg <= {shreg[BYTE_BITS-2:0], sda_s};
                     if (bitcnt == LAST_BIT) begin
                        byte_full <= 1'b1;
                        bitcnt    <= '0;
                     end else begin
                        bitcnt <= bitcnt + 1'b1;
                     end
                  end
                  if (fall_i && byte_full) begin
                     byte_full <= 1'b0;
                     if (state == ST_ADDR) begin
                        if (addr_ok) begin
                           oe_q  <= 1'b1;
                           state <= ST_ADDR_ACK;
                        end else begin
                           state <= ST_SKIP;
                        end
                     end else begin
                        if (!busy_i) begin
                           oe_q  <= 1'b1;
                           pend  <= decode_op(shreg[1:0]);
                           state <= ST_CMD_ACK;
                        end else begin
                           state <= ST_SKIP;
                        end
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (fall_i) begin
                     oe_q  <= 1'b0;
                     state <= ST_CMD;
                  end
               end
               ST_CMD_ACK: begin
                  if (fall_i) begin
                     oe_q  <= 1'b0;
                     state <= ST_HOLD;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign oe_o      = oe_q;
   assign save_o    = save_q;
   assign restore_o = restore_q;

   AST_ACK_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_q) |-> !$past(busy_i)); // R4

   AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(oe_q) || $fell(oe_q)) |-> (!scl_s || $past(start_i) || $past(stop_i))); // R1

   AST_SAVE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      save_q |=> !save_q); // R3

   AST_RESTORE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      restore_q |=> !restore_q); // R3

endmodule

// File: rtl/cmd_i2c_target.sv
module cmd_i2c_target #(
   parameter int ADDR_W = 7,
   parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h6A,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic sda_oe,
   input  logic busy,
   output logic save_go,
   output logic restore_go
);

   logic [1:0] bus_s;
   logic scl_s, sda_s;
   logic start_w, stop_w, rise_w, fall_w;

   cmd_i2c_sync #(
      .WIDTH  (2),
      .STAGES (SYNC_STAGES),
      .RST_VAL(1'b1)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_in ({scl_in, sda_in}),
      .d_out(bus_s)
   );

   assign scl_s = bus_s[1];
   assign sda_s = bus_s[0];

   cmd_i2c_cond u_cond (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .start_det(start_w),
      .stop_det (stop_w),
      .scl_rise (rise_w),
      .scl_fall (fall_w)
   );

   cmd_i2c_fsm #(
      .ADDR_W  (ADDR_W),
      .DEV_ADDR(DEV_ADDR)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .start_i  (start_w),
      .stop_i   (stop_w),
      .rise_i   (rise_w),
      .fall_i   (fall_w),
      .busy_i   (busy),
      .oe_o     (sda_oe),
      .save_o   (save_go),
      .restore_o(restore_go)
   );

   AST_GO_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(save_go && restore_go)); // R2

   AST_GO_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (save_go || restore_go) |-> $past(stop_w)); // R3

endmodule

// File: tb/tb_cmd_i2c_target.sv
module tb_cmd_i2c_target;

   localparam int Q = 8;
   localparam int NVEC = 9;
   // {addr[7], rw, cmd[8], busy, exp_ack_addr, exp_ack_cmd, exp_save, exp_restore}
   localparam logic [20:0] VEC [NVEC] = '{
      {7'h6A, 1'b0, 8'h01, 1'b0, 4'b1110},   // R1 R2 save
      {7'h6A, 1'b0, 8'hFE, 1'b0, 4'b1101},   // R2 restore, upper bits set
      {7'h6A, 1'b0, 8'hFD, 1'b0, 4'b1110},   // R2 save, upper bits set
      {7'h6A, 1'b0, 8'h00, 1'b0, 4'b1100},   // R7
      {7'h6A, 1'b0, 8'h03, 1'b0, 4'b1100},   // R7
      {7'h2A, 1'b0, 8'h01, 1'b0, 4'b0000},   // R1 mismatch
      {7'h6A, 1'b1, 8'h01, 1'b0, 4'b0000},   // R1 read bit
      {7'h6A, 1'b0, 8'h02, 1'b1, 4'b0000},   // R4 busy
      {7'h6A, 1'b0, 8'h02, 1'b0, 4'b1101}    // R5 recovered
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic busy = 1'b0;
   logic sda_oe, save_go, restore_go;
   logic sda_line;

   int n_tests = 0;
   int n_fail = 0;
   int save_cnt = 0;
   int rest_cnt = 0;
   logic done = 1'b0;

   always #2.5 clk = ~clk;

   assign sda_line = m_sda & ~sda_oe;

   cmd_i2c_target dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (m_scl),
      .sda_in    (sda_line),
      .sda_oe    (sda_oe),
      .busy      (busy),
      .save_go   (save_go),
      .restore_go(restore_go)
   );

   always @(negedge clk) begin
      if (save_go) save_cnt++;
      if (restore_go) rest_cnt++;
   end

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic bus_start();
      m_sda = 1'b1; m_scl = 1'b1; waitc(Q);
      m_sda = 1'b0; waitc(Q);
      m_scl = 1'b0; waitc(Q);
   endtask

   task automatic bus_rstart();
      m_sda = 1'b1; waitc(Q);
      m_scl = 1'b1; waitc(Q);
      m_sda = 1'b0; waitc(Q);
      m_scl = 1'b0; waitc(Q);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; waitc(Q);
      m_scl = 1'b1; waitc(Q);
      m_sda = 1'b1; waitc(2*Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output int acked);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; waitc(Q);
         m_scl = 1'b1; waitc(2*Q);
         m_scl = 1'b0; waitc(Q);
      end
      m_sda = 1'b1; waitc(Q);
      m_scl = 1'b1; waitc(Q);
      acked = (sda_line == 1'b0) ? 1 : 0;
      waitc(Q);
      m_scl = 1'b0; waitc(Q);
   endtask

   initial begin
      int a0, a1, s0, r0;
      waitc(4);
      // R8 reset state
      chk("R8 sda_oe", int'(sda_oe), 0);
      chk("R8 save_go", int'(save_go), 0);
      chk("R8 restore_go", int'(restore_go), 0);
      rst_n = 1'b1;
      waitc(4);

      for (int v = 0; v < NVEC; v++) begin
         busy = VEC[v][4];
         s0 = save_cnt; r0 = rest_cnt;
         bus_start();
         send_byte({VEC[v][20:14], VEC[v][13]}, a0);
         send_byte(VEC[v][12:5], a1);
         chk($sformatf("R1 vec%0d addr ack", v), a0, int'(VEC[v][3]));
         chk($sformatf("R4 vec%0d cmd ack", v), a1, int'(VEC[v][2]));
         chk($sformatf("R3 vec%0d no pulse before stop", v), save_cnt + rest_cnt - s0 - r0, 0);
         bus_stop();
         waitc(Q);
         chk($sformatf("R2 vec%0d save pulses", v), save_cnt - s0, int'(VEC[v][1]));
         chk($sformatf("R2 vec%0d restore pulses", v), rest_cnt - r0, int'(VEC[v][0]));
      end

      // R3 deferral: long gap between command byte and STOP
      busy = 1'b0;
      s0 = save_cnt;
      bus_start();
      send_byte({7'h6A, 1'b0}, a0);
      send_byte(8'h01, a1);
      waitc(40);
      chk("R3 held until stop", save_cnt - s0, 0);
      bus_stop();
      waitc(Q);
      chk("R3 single pulse after stop", save_cnt - s0, 1);

      // R6 repeated START discards pending command
      s0 = save_cnt; r0 = rest_cnt;
      bus_start();
      send_byte({7'h6A, 1'b0}, a0);
      send_byte(8'h01, a1);
      bus_rstart();
      send_byte({7'h6A, 1'b0}, a0);
      chk("R6 addr acked after repeated start", a0, 1);
      send_byte(8'h00, a1);
      bus_stop();
      waitc(Q);
      chk("R6 discarded save", save_cnt - s0, 0);
      chk("R6 no restore", rest_cnt - r0, 0);

      // R6 repeated START then STOP with no new command
      s0 = save_cnt; r0 = rest_cnt;
      bus_start();
      send_byte({7'h6A, 1'b0}, a0);
      send_byte(8'h02, a1);
      bus_rstart();
      bus_stop();
      waitc(Q);
      chk("R6 discarded restore", rest_cnt - r0, 0);

      // R1 bus released at idle
      chk("R1 sda released idle", int'(sda_oe), 0);
      done = 1'b1;
   end

   initial begin
      int cyc;
      cyc = 0;
      while (!done && cyc < 150000) begin
         @(negedge clk);
         cyc++;
      end
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=done", cyc);
      end
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule